// File: doc/BRIEF.md
# GPS-gated frequency-locked loop controller

This block disciplines a nominal 10 MHz oscillator against a one-pulse-per-second timing reference. It runs on the oscillator clock. A free-running edge counter is latched on each synchronized reference edge. Every 16 reference intervals it closes a measurement gate, and the gate's edge count is the difference between two latched values. The block subtracts a configured nominal count from this number to get a signed frequency error. Any error whose magnitude exceeds a configured limit is thrown away.

Accepted errors are gathered over an averaging cycle of 2^k accepted samples. In summing mode the correction is the negated mean error. In voting mode only the sign of each error counts, and the 14-bit tuning word moves one step against the majority. A slope bit inverts the correction for oscillators whose frequency falls as the tuning word rises. After every tuning update the next full gate is a settling pause, and its result is discarded.

Top module: `fll_gate_ctrl`

## Requirements
- R1: After reset the tuning word is 8192 and the strobes sample_done, sample_accepted, sample_rejected and tune_update are all low.
- R2: Each gate spans exactly 16 consecutive intervals of the synchronized reference. The sample is the number of oscillator rising edges in that span, and the error is the sample minus cfg_nominal. Gates follow one another with no gap, and sample_done pulses for one cycle as each gate closes.
- R3: The first synchronized reference edge after reset only opens the first gate and produces no sample.
- R4: A sample whose error magnitude is at most cfg_limit (the limit is inclusive) is accepted and pulses sample_accepted. Any other sample pulses sample_rejected and contributes nothing to the average.
- R5: An averaging cycle ends on the 2^cfg_avg_log2-th accepted sample. tune_update then pulses and the tuning word is corrected once.
- R6: Summing mode (cfg_vote_mode = 0) gives a correction of minus floor(sum of errors / 2^cfg_avg_log2).
- R7: Voting mode (cfg_vote_mode = 1) counts positive errors as +1 and negative errors as -1. A positive tally gives a correction of -1, a negative tally gives +1, and a tie or zero gives 0.
- R8: When cfg_neg_slope = 1 the sign of the correction is inverted.
- R9: After every tuning update, including one with zero correction, the next gate is a settling pause. It pulses sample_done but neither sample_accepted nor sample_rejected.
- R10: The tuning word saturates at 0 and 16383 and never wraps.
- R11: The tuning word changes only in a cycle in which tune_update is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock under discipline |
| rst_n | input | 1 | Active-low synchronous reset |
| pps_in | input | 1 | Asynchronous reference pulse, one per second |
| cfg_nominal | input | CW | Expected edge count per gate |
| cfg_limit | input | CW | Largest error magnitude that is accepted |
| cfg_avg_log2 | input | 3 | Log2 of accepted samples per averaging cycle |
| cfg_vote_mode | input | 1 | 0 selects summing mode, 1 selects voting mode |
| cfg_neg_slope | input | 1 | Inverts the correction direction |
| tune_word | output | 14 | Oscillator tuning word |
| sample_done | output | 1 | Pulses when a gate closes |
| sample_accepted | output | 1 | Pulses for a sample that falls within the limit |
| sample_rejected | output | 1 | Pulses for an outlier sample |
| tune_update | output | 1 | Pulses when an averaging cycle applies its correction |

## Verification
The hardest states to reach from the ports are the two saturation limits. Each needs gates whose length is far from nominal, and they have to be accepted under a widened limit. The bench stretches the reference period to three and then eleven times nominal. With the slope chosen so each correction runs toward the rail, a few large updates drive the word past 0 and then past 16383. Each gate is built from exactly 16 reference pulses with a known period, so the bench knows every sample's error. It runs a small averaging model of its own to predict the tuning word and the strobe counts after each gate.

// File: rtl/fll_pkg.sv
package fll_pkg;
  localparam int TUNE_W   = 14;
  localparam int TUNE_MAX = (1 << TUNE_W) - 1;
  localparam int DELTA_W  = 48;

  // Clamp cur + delta into [0, TUNE_MAX].
  function automatic logic [TUNE_W-1:0] tune_sat(input logic [TUNE_W-1:0] cur,
                                                 input logic signed [DELTA_W-1:0] delta);
    logic signed [DELTA_W:0] nxt;
    nxt = $signed({{(DELTA_W-TUNE_W+1){1'b0}}, cur}) + $signed({delta[DELTA_W-1], delta});
    if (nxt < 0) return '0;
    else if (nxt > TUNE_MAX) return TUNE_W'(TUNE_MAX);
    else return nxt[TUNE_W-1:0];
  endfunction

  // Majority of signs: frequency high -> step down.
  function automatic logic signed [1:0] vote_dir(input logic signed [15:0] tally);
    if (tally > 0) return -2'sd1;
    else if (tally < 0) return 2'sd1;
    else return 2'sd0;
  endfunction

  function automatic logic within_limit(input logic signed [DELTA_W-1:0] err,
                                        input logic [DELTA_W-1:0] lim);
    logic [DELTA_W-1:0] mag;
    mag = (err < 0) ? $unsigned(-err) : $unsigned(err);
    return mag <= lim;
  endfunction
endpackage

// File: rtl/fll_pps_sync.sv
module fll_pps_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pps_in,
  output logic pps_tick
);
  logic s1, s2, s3;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pps_in;
      s2 <= s1;
      s3 <= s2;
    end
  end
  assign pps_tick = s2 & ~s3;
endmodule

// File: rtl/fll_gate_counter.sv
module fll_gate_counter #(
  parameter int CW         = 32,
  parameter int GATE_TICKS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pps_tick,
  output logic          sample_done,
  output logic [CW-1:0] sample_count
);
  localparam int IW = (GATE_TICKS > 1) ? $clog2(GATE_TICKS) : 1;

  logic [CW-1:0] free_cnt;
  logic [CW-1:0] base;
  logic [IW-1:0] idx;
  logic          started;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_cnt     <= '0;
      base         <= '0;
      idx          <= '0;
      started      <= 1'b0;
      sample_done  <= 1'b0;
      sample_count <= '0;
    end else begin
      free_cnt    <= free_cnt + 1'b1;
      sample_done <= 1'b0;
      if (pps_tick) begin
        if (!started) begin
          started <= 1'b1;
          base    <= free_cnt;
          idx     <= '0;
        end else if (idx == IW'(GATE_TICKS - 1)) begin
          sample_done  <= 1'b1;
          sample_count <= free_cnt - base;
          base         <= free_cnt;
          idx          <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fll_averager.sv
module fll_averager
  import fll_pkg::*;
#(
  parameter int CW     = 32,
  parameter int LOG2_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sample_done,
  input  logic                      settling,
  input  logic [CW-1:0]             sample_count,
  input  logic [CW-1:0]             cfg_nominal,
  input  logic [CW-1:0]             cfg_limit,
  input  logic [LOG2_W-1:0]         cfg_avg_log2,
  input  logic                      cfg_vote_mode,
  input  logic                      cfg_neg_slope,
  output logic                      sample_accepted,
  output logic                      sample_rejected,
  output logic                      avg_update,
  output logic signed [DELTA_W-1:0] avg_delta
);
  localparam int MAXN = 1 << ((1 << LOG2_W) - 1);
  localparam int NW   = $clog2(MAXN + 1);
  localparam int VW   = NW + 1;

  logic signed [CW:0]         err;
  logic signed [DELTA_W-1:0]  err_x, sum, sum_next, shifted, raw, corr;
  logic signed [VW-1:0]       votes, votes_next;
  logic [NW-1:0]              n, n_inc, target;
  logic                       in_lim, last;

  assign err        = $signed({1'b0, sample_count}) - $signed({1'b0, cfg_nominal});
  assign err_x      = DELTA_W'(err);
  assign in_lim     = within_limit(err_x, DELTA_W'(cfg_limit));
  assign sum_next   = sum + err_x;
  assign votes_next = votes + ((err_x > 0) ? VW'(1) : VW'(0)) - ((err_x < 0) ? VW'(1) : VW'(0));
  assign n_inc      = n + 1'b1;
  assign target     = NW'(1) << cfg_avg_log2;
  assign last       = (n_inc == target);
  assign shifted    = sum_next >>> cfg_avg_log2;
  assign raw        = cfg_vote_mode ? DELTA_W'(vote_dir(16'(votes_next))) : -shifted;
  assign corr       = cfg_neg_slope ? -raw : raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum             <= '0;
      votes           <= '0;
      n               <= '0;
      sample_accepted <= 1'b0;
      sample_rejected <= 1'b0;
      avg_update      <= 1'b0;
      avg_delta       <= '0;
    end else begin
      sample_accepted <= 1'b0;
      sample_rejected <= 1'b0;
      avg_update      <= 1'b0;
      if (sample_done && !settling) begin
        if (in_lim) begin
          sample_accepted <= 1'b1;
          if (last) begin
            avg_update <= 1'b1;
            avg_delta  <= corr;
            sum        <= '0;
            votes      <= '0;
            n          <= '0;
          end else begin
            sum   <= sum_next;
            votes <= votes_next;
            n     <= n_inc;
          end
        end else begin
          sample_rejected <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fll_gate_ctrl.sv
module fll_gate_ctrl
  import fll_pkg::*;
#(
  parameter int CW         = 32,
  parameter int GATE_TICKS = 16,
  parameter int LOG2_W     = 3,
  parameter int TUNE_INIT  = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pps_in,
  input  logic [CW-1:0]     cfg_nominal,
  input  logic [CW-1:0]     cfg_limit,
  input  logic [LOG2_W-1:0] cfg_avg_log2,
  input  logic              cfg_vote_mode,
  input  logic              cfg_neg_slope,
  output logic [TUNE_W-1:0] tune_word,
  output logic              sample_done,
  output logic              sample_accepted,
  output logic              sample_rejected,
  output logic              tune_update
);
  logic                      pps_tick;
  logic [CW-1:0]             sample_count;
  logic                      settling;
  logic                      avg_update;
  logic signed [DELTA_W-1:0] avg_delta;

  fll_pps_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .pps_tick(pps_tick)
  );

  fll_gate_counter #(.CW(CW), .GATE_TICKS(GATE_TICKS)) u_gate (
    .clk(clk), .rst_n(rst_n), .pps_tick(pps_tick),
    .sample_done(sample_done), .sample_count(sample_count)
  );

  fll_averager #(.CW(CW), .LOG2_W(LOG2_W)) u_avg (
    .clk(clk), .rst_n(rst_n), .sample_done(sample_done), .settling(settling),
    .sample_count(sample_count), .cfg_nominal(cfg_nominal), .cfg_limit(cfg_limit),
    .cfg_avg_log2(cfg_avg_log2), .cfg_vote_mode(cfg_vote_mode),
    .cfg_neg_slope(cfg_neg_slope), .sample_accepted(sample_accepted),
    .sample_rejected(sample_rejected), .avg_update(avg_update), .avg_delta(avg_delta)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tune_word   <= TUNE_W'(TUNE_INIT);
      tune_update <= 1'b0;
      settling    <= 1'b0;
    end else begin
      tune_update <= avg_update;
      if (avg_update) begin
        tune_word <= tune_sat(tune_word, avg_delta);
        settling  <= 1'b1;
      end else if (sample_done) begin
        settling <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fll_gate_chk.sv
module fll_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pps_tick,
  input logic        sample_done,
  input logic        sample_accepted,
  input logic        sample_rejected,
  input logic        tune_update,
  input logic        settling,
  input logic [13:0] tune_word
);
  // R4
  acc_rej_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_accepted && sample_rejected));

  // R2
  gate_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_done |-> $past(pps_tick));

  // R4
  verdict_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_accepted || sample_rejected) |-> $past(sample_done));

  // R9
  settle_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tune_update |-> settling);

  // R9
  settle_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settling && sample_done) |=> !(sample_accepted || sample_rejected));

  // R11
  tune_only_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tune_word) |-> tune_update);
endmodule

bind fll_gate_ctrl fll_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pps_tick(pps_tick), .sample_done(sample_done),
  .sample_accepted(sample_accepted), .sample_rejected(sample_rejected),
  .tune_update(tune_update), .settling(settling), .tune_word(tune_word)
);

// File: tb/test_fll_gate_ctrl.sv
module test_fll_gate_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pps_in = 1'b0;
  logic [31:0] cfg_nominal = 32'd1600;
  logic [31:0] cfg_limit = 32'd50;
  logic [2:0]  cfg_avg_log2 = 3'd1;
  logic        cfg_vote_mode = 1'b0;
  logic        cfg_neg_slope = 1'b0;
  logic [13:0] tune_word;
  logic        sample_done, sample_accepted, sample_rejected, tune_update;

  always #10 clk = ~clk;

  fll_gate_ctrl i_fll_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .cfg_nominal(cfg_nominal),
    .cfg_limit(cfg_limit), .cfg_avg_log2(cfg_avg_log2), .cfg_vote_mode(cfg_vote_mode),
    .cfg_neg_slope(cfg_neg_slope), .tune_word(tune_word), .sample_done(sample_done),
    .sample_accepted(sample_accepted), .sample_rejected(sample_rejected),
    .tune_update(tune_update)
  );

  int checks = 0, errors = 0;
  int n_done = 0, n_acc = 0, n_rej = 0, n_upd = 0;
  int e_done = 0, e_acc = 0, e_rej = 0, e_upd = 0;
  longint e_tune = 8192, m_sum = 0, m_vote = 0, m_n = 0;
  bit m_settle = 0;
  int lag = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (sample_done) n_done++;
      if (sample_accepted) n_acc++;
      if (sample_rejected) n_rej++;
      if (tune_update) n_upd++;
    end
  end

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic pulse(input int p);
    repeat (p - 2 - lag) @(negedge clk);
    lag = 0;
    pps_in = 1'b1;
    repeat (2) @(negedge clk);
    pps_in = 1'b0;
  endtask

  function automatic longint floor_div(input longint a, input longint b);
    longint q;
    q = a / b;
    if ((a % b != 0) && (a < 0)) q = q - 1;
    return q;
  endfunction

  // Bench model of one gate, built from R2 and R4 to R10.
  task automatic model_gate(input int p);
    longint err, d;
    err = 16 * longint'(p) - longint'(cfg_nominal);
    e_done++;
    if (m_settle) begin
      m_settle = 0;
    end else if ((err < 0 ? -err : err) <= longint'(cfg_limit)) begin
      e_acc++;
      m_sum += err;
      m_vote += (err > 0) ? 1 : ((err < 0) ? -1 : 0);
      m_n++;
      if (m_n == (longint'(1) << cfg_avg_log2)) begin
        if (cfg_vote_mode) d = (m_vote > 0) ? -1 : ((m_vote < 0) ? 1 : 0);
        else d = -floor_div(m_sum, longint'(1) << cfg_avg_log2);
        if (cfg_neg_slope) d = -d;
        e_tune += d;
        if (e_tune < 0) e_tune = 0;
        if (e_tune > 16383) e_tune = 16383;
        e_upd++;
        m_settle = 1;
        m_sum = 0; m_vote = 0; m_n = 0;
      end
    end else begin
      e_rej++;
    end
  endtask

  task automatic run_gate(input int p, input string tag);
    repeat (16) pulse(p);
    repeat (8) @(negedge clk);
    lag = 8;
    model_gate(p);
    check(tag, "sample_done count", n_done, e_done);
    check(tag, "accepted count", n_acc, e_acc);
    check(tag, "rejected count", n_rej, e_rej);
    check(tag, "update count", n_upd, e_upd);
    check(tag, "tune_word", tune_word, e_tune);
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    // R1
    check("R1", "tune_word after reset", tune_word, 8192);
    check("R1", "strobes after reset",
          {sample_done, sample_accepted, sample_rejected, tune_update}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    pulse(100);
    repeat (8) @(negedge clk);
    lag = 8;
    // R3: opening edge yields no sample
    check("R3", "no sample on first edge", n_done, 0);
  endtask

  task automatic t_summing;
    cfg_limit = 50; cfg_avg_log2 = 1; cfg_vote_mode = 0; cfg_neg_slope = 0;
    run_gate(101, "R2");  // +16
    run_gate(102, "R6");  // +32 -> mean 24, word down 24 (R5)
    run_gate(100, "R9");  // settling pause
  endtask

  task automatic t_reject;
    run_gate(110, "R4");  // +160 outlier
    run_gate(99, "R4");   // -16
    run_gate(97, "R5");   // -48 -> up 32
    run_gate(100, "R9");
  endtask

  task automatic t_limit_edge;
    cfg_limit = 48; cfg_avg_log2 = 0;
    run_gate(103, "R4");  // +48 equals limit, accepted
    run_gate(100, "R9");
    run_gate(104, "R4");  // +64 rejected
    run_gate(96, "R4");   // -64 rejected
  endtask

  task automatic t_voting;
    cfg_vote_mode = 1; cfg_avg_log2 = 2;
    run_gate(101, "R7");
    run_gate(101, "R7");
    run_gate(99, "R7");
    run_gate(101, "R7");  // tally +2 -> step -1
    run_gate(100, "R9");
    cfg_avg_log2 = 1;
    run_gate(101, "R7");
    run_gate(99, "R7");   // tie -> zero step, still settles
    run_gate(101, "R9");  // discarded despite error
  endtask

  task automatic t_slope;
    cfg_vote_mode = 0; cfg_avg_log2 = 0; cfg_neg_slope = 1;
    run_gate(101, "R8");  // +16 error -> word up 16
    run_gate(100, "R9");
  endtask

  task automatic t_saturate;
    cfg_neg_slope = 0; cfg_limit = 4000;
    run_gate(300, "R10");
    run_gate(100, "R9");
    run_gate(300, "R10");
    run_gate(100, "R9");
    run_gate(300, "R10");  // clamps at 0
    run_gate(100, "R9");
    cfg_neg_slope = 1; cfg_limit = 20000;
    run_gate(1100, "R10");
    run_gate(100, "R9");
    run_gate(1100, "R10"); // clamps at 16383
  endtask

  initial begin
    t_reset();
    t_summing();
    t_reject();
    t_limit_edge();
    t_voting();
    t_slope();
    t_saturate();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule